// File: doc/BRIEF.md
# Memory Bus Module Address Router

The router sits between one processor's memory bus and the memory modules behind it. It watches the processor's request and write-restart lines. It turns each rising edge into a one-cycle strobe and sends that strobe to exactly one module: the small fast memory or one of sixteen core modules. Each core module covers a 16K-word window. The memory answers with address-acknowledge and read-restart lines. The router passes the rising edges of those lines back to the processor as one-cycle pulses.

Routing uses a fast-memory select line and four high address lines. A request with the select line set goes first to the fast memory. If the fast memory is missing, or declines the cycle, the same request is decoded as a core access. The four high address lines form the core module index in reversed significance. When no attached module can take a request, the router raises a one-cycle nonexistent-memory pulse. It raises the same pulse when a routed request gets no acknowledge within a parameterised window.

Top module: `mbr_router`

## Requirements
- R1: A request is forwarded only on a rising edge of `bus_rq_cyc`, as a strobe one clock cycle wide that appears one cycle after the edge. Keeping the line high does not produce a second strobe.
- R2: When `bus_fm_sel`, `fm_present` and `fm_claim` are all 1 at the edge, the strobe goes to `fm_rq` and no `core_rq` bit is set.
- R3: When `bus_fm_sel` is 1 but the fast memory is absent or does not claim the cycle, the request is decoded as a core access exactly as if `bus_fm_sel` were 0.
- R4: `bus_hi_lines[i]` carries high address line 18+i. The core index is bit 3 = `bus_hi_lines[0]`, bit 2 = `bus_hi_lines[1]`, bit 1 = `bus_hi_lines[2]` and bit 0 = `bus_hi_lines[3]`. Index k selects `core_rq[k]`, which covers words k*2^14 to k*2^14+16383.
- R5: A core request to an index whose `core_present` bit is 0 produces no strobe. Instead `nxm` is 1 for one cycle, at the moment the strobe would have appeared.
- R6: A rising edge of `bus_wr_rs` gives a one-cycle pulse one cycle later on the write-restart output of the module that took the last routed request: `fm_wr` or `core_wr[k]`. Keeping the line high gives no second pulse. After a request that ended in nonexistent memory, the write restart has no effect on any output.
- R7: Rising edges of `mem_addr_ack` and `mem_rd_rs` reach `proc_addr_ack` and `proc_rd_rs` as one-cycle pulses one cycle later.
- R8: If no rising edge of `mem_addr_ack` arrives within TIMEOUT clock edges after a routed request edge, `nxm` is 1 for one cycle, TIMEOUT cycles after the strobe. An acknowledge edge within the window cancels the pending indication.
- R9: While `rst_n` is 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rq_cyc | input | 1 | Processor cycle request line |
| bus_wr_rs | input | 1 | Processor write-restart line |
| bus_fm_sel | input | 1 | Fast-memory select line |
| bus_hi_lines | input | 4 | High address lines; bit i is address line 18+i |
| fm_present | input | 1 | Fast memory is attached |
| fm_claim | input | 1 | Fast memory accepts this cycle |
| core_present | input | 16 | One bit per attached core module |
| mem_addr_ack | input | 1 | Address acknowledge from memory |
| mem_rd_rs | input | 1 | Read restart from memory |
| fm_rq | output | 1 | Request strobe to fast memory |
| fm_wr | output | 1 | Write-restart strobe to fast memory |
| core_rq | output | 16 | Request strobe per core module |
| core_wr | output | 16 | Write-restart strobe per core module |
| proc_addr_ack | output | 1 | Address-acknowledge pulse to processor |
| proc_rd_rs | output | 1 | Read-restart pulse to processor |
| nxm | output | 1 | Nonexistent-memory pulse |

## Verification
A stale edge-history register shows up as a missing strobe, or as a repeated strobe while a line stays high. Either is visible one cycle after the stimulus. A wrong index mapping, or wrong fast-memory fall-through, lights the wrong one of seventeen strobe outputs in the same cycle the request is forwarded. A stale route register misdirects the next write-restart pulse. A timeout counter that is off by one moves the `nxm` pulse by a cycle, so the bench counts edges exactly around the TIMEOUT boundary.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
   localparam int DEF_SEL_W   = 4;
   localparam int DEF_TIMEOUT = 16;

   // edge-detector lane positions
   localparam int LN_RQ  = 0;
   localparam int LN_WR  = 1;
   localparam int LN_ACK = 2;
   localparam int LN_RD  = 3;
   localparam int LANES  = 4;
endpackage

// File: rtl/mbr_edge.sv
module mbr_edge #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lines,
   output logic [W-1:0] rise
);
   logic [W-1:0] hist_q;

   always_ff @(posedge clk) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= lines;
   end

   // rising edge: changed since last step and now high
   assign rise = (hist_q ^ lines) & lines;
endmodule

// File: rtl/mbr_decode.sv
module mbr_decode #(
   parameter int SEL_W = 4,
   localparam int NMOD = 1 << SEL_W
) (
   input  logic [SEL_W-1:0] hi_lines,
   input  logic [NMOD-1:0]  present,
   input  logic             fm_sel,
   input  logic             fm_present,
   input  logic             fm_claim,
   output logic             go_fast,
   output logic             go_core,
   output logic             absent,
   output logic [NMOD-1:0]  onehot
);
   logic [SEL_W-1:0] idx;

   // lowest-numbered line lands in the most significant index bit
   for (genvar b = 0; b < SEL_W; b++) begin : g_rev
      assign idx[b] = hi_lines[SEL_W-1-b];
   end

   for (genvar m = 0; m < NMOD; m++) begin : g_hot
      assign onehot[m] = (idx == SEL_W'(m));
   end

   assign go_fast = fm_sel & fm_present & fm_claim;
   assign go_core = !go_fast && present[idx];
   assign absent  = !go_fast && !present[idx];
endmodule

// File: rtl/mbr_timer.sv
module mbr_timer #(
   parameter int TIMEOUT = 16,
   localparam int CNT_W = $clog2(TIMEOUT)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic stop,
   output logic expire
);
   logic             wait_q;
   logic [CNT_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = (cnt_q == CNT_W'(TIMEOUT - 1));
   assign expire = wait_q && at_end && !stop && !start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         wait_q <= 1'b1;
         cnt_q  <= '0;
      end else if (stop || expire) begin
         wait_q <= 1'b0;
         cnt_q  <= '0;
      end else if (wait_q) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/mbr_router.sv
module mbr_router
   import mbr_pkg::*;
#(
   parameter int SEL_W   = DEF_SEL_W,
   parameter int TIMEOUT = DEF_TIMEOUT,
   localparam int NMOD   = 1 << SEL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rq_cyc,
   input  logic             bus_wr_rs,
   input  logic             bus_fm_sel,
   input  logic [SEL_W-1:0] bus_hi_lines,
   input  logic             fm_present,
   input  logic             fm_claim,
   input  logic [NMOD-1:0]  core_present,
   input  logic             mem_addr_ack,
   input  logic             mem_rd_rs,
   output logic             fm_rq,
   output logic             fm_wr,
   output logic [NMOD-1:0]  core_rq,
   output logic [NMOD-1:0]  core_wr,
   output logic             proc_addr_ack,
   output logic             proc_rd_rs,
   output logic             nxm
);
   if (SEL_W < 1 || SEL_W > 6) begin : g_bad_sel
      $error("mbr_router: SEL_W out of range");
   end
   if (TIMEOUT < 2) begin : g_bad_to
      $error("mbr_router: TIMEOUT must be at least 2");
   end

   logic [LANES-1:0] lanes, rise;
   logic             go_fast, go_core, absent, expire;
   logic [NMOD-1:0]  hot;
   logic             rt_valid_q, rt_fast_q;
   logic [NMOD-1:0]  rt_hot_q;
   logic             rq_e, routed;

   always_comb begin
      lanes         = '0;
      lanes[LN_RQ]  = bus_rq_cyc;
      lanes[LN_WR]  = bus_wr_rs;
      lanes[LN_ACK] = mem_addr_ack;
      lanes[LN_RD]  = mem_rd_rs;
   end

   mbr_edge #(.W(LANES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lines (lanes),
      .rise  (rise)
   );

   mbr_decode #(.SEL_W(SEL_W)) u_dec (
      .hi_lines   (bus_hi_lines),
      .present    (core_present),
      .fm_sel     (bus_fm_sel),
      .fm_present (fm_present),
      .fm_claim   (fm_claim),
      .go_fast    (go_fast),
      .go_core    (go_core),
      .absent     (absent),
      .onehot     (hot)
   );

   assign rq_e   = rise[LN_RQ];
   assign routed = rq_e && (go_fast || go_core);

   mbr_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (routed),
      .stop   (rise[LN_ACK]),
      .expire (expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fm_rq         <= 1'b0;
         fm_wr         <= 1'b0;
         core_rq       <= '0;
         core_wr       <= '0;
         proc_addr_ack <= 1'b0;
         proc_rd_rs    <= 1'b0;
         nxm           <= 1'b0;
         rt_valid_q    <= 1'b0;
         rt_fast_q     <= 1'b0;
         rt_hot_q      <= '0;
      end else begin
         fm_rq         <= rq_e && go_fast;
         core_rq       <= (rq_e && go_core) ? hot : '0;
         nxm           <= (rq_e && absent) || expire;
         proc_addr_ack <= rise[LN_ACK];
         proc_rd_rs    <= rise[LN_RD];
         fm_wr         <= rise[LN_WR] && rt_valid_q && rt_fast_q;
         core_wr       <= (rise[LN_WR] && rt_valid_q) ? rt_hot_q : '0;
         if (routed) begin
            rt_valid_q <= 1'b1;
            rt_fast_q  <= go_fast;
            rt_hot_q   <= go_fast ? '0 : hot;
         end else if (rq_e) begin
            rt_valid_q <= 1'b0;
            rt_fast_q  <= 1'b0;
            rt_hot_q   <= '0;
         end
      end
   end
endmodule

// File: rtl/mbr_router_chk.sv
module mbr_router_chk #(
   parameter int SEL_W = 4,
   localparam int NMOD = 1 << SEL_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NMOD-1:0]  core_present,
   input logic             fm_rq,
   input logic             fm_wr,
   input logic [NMOD-1:0]  core_rq,
   input logic [NMOD-1:0]  core_wr,
   input logic             proc_addr_ack,
   input logic             nxm
);
   // R2: at most one module strobed per request
   a_r2_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fm_rq, core_rq}));

   // R6: write restart reaches at most one module
   a_r6_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fm_wr, core_wr}));

   // R5: a strobe only reaches a module marked present
   a_r5_present_only: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rq != '0) |-> ((core_rq & ~$past(core_present)) == '0));

   // R5: a nonexistent-memory pulse never coincides with a strobe
   a_r5_nxm_excl: assert property (@(posedge clk) disable iff (!rst_n)
      nxm |-> !(fm_rq || (core_rq != '0)));

   // R1: request strobes last one cycle
   a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (fm_rq || (core_rq != '0)) |=> !(fm_rq || (core_rq != '0)));

   // R7: acknowledge pulse lasts one cycle
   a_r7_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      proc_addr_ack |=> !proc_addr_ack);
endmodule

bind mbr_router mbr_router_chk #(.SEL_W(SEL_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .core_present  (core_present),
   .fm_rq         (fm_rq),
   .fm_wr         (fm_wr),
   .core_rq       (core_rq),
   .core_wr       (core_wr),
   .proc_addr_ack (proc_addr_ack),
   .nxm           (nxm)
);

// File: tb/tb_mbr_router.sv
module tb_mbr_router;
   localparam int TO = 6;
   localparam int NV = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_rq_cyc = 1'b0, bus_wr_rs = 1'b0, bus_fm_sel = 1'b0;
   logic [3:0]  bus_hi_lines = '0;
   logic        fm_present = 1'b0, fm_claim = 1'b0;
   logic [15:0] core_present = '0;
   logic        mem_addr_ack = 1'b0, mem_rd_rs = 1'b0;
   logic        fm_rq, fm_wr, proc_addr_ack, proc_rd_rs, nxm;
   logic [15:0] core_rq, core_wr;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   mbr_router #(.SEL_W(4), .TIMEOUT(TO)) dut (.*);

   // {fm_sel, fm_present, fm_claim, hi[3:0], mask[15:0], exp_fm, exp_core_valid, exp_idx[3:0], exp_nxm}
   localparam logic [29:0] VECS [NV] = '{
      {3'b000, 4'b0001, 16'hFFFF, 1'b0, 1'b1, 4'd8,  1'b0},  // line18 -> idx 8
      {3'b000, 4'b1000, 16'hFFFF, 1'b0, 1'b1, 4'd1,  1'b0},  // line21 -> idx 1
      {3'b000, 4'b0011, 16'hFFFF, 1'b0, 1'b1, 4'd12, 1'b0},
      {3'b000, 4'b1101, 16'hFFFF, 1'b0, 1'b1, 4'd11, 1'b0},
      {3'b111, 4'b0011, 16'hFFFF, 1'b1, 1'b0, 4'd0,  1'b0},  // fast claimed
      {3'b110, 4'b0011, 16'hFFFF, 1'b0, 1'b1, 4'd12, 1'b0},  // unclaimed falls through
      {3'b101, 4'b0000, 16'hFFFF, 1'b0, 1'b1, 4'd0,  1'b0},  // fast absent
      {3'b000, 4'b0001, 16'hFEFF, 1'b0, 1'b0, 4'd0,  1'b1},  // idx 8 missing
      {3'b110, 4'b1000, 16'h0000, 1'b0, 1'b0, 4'd0,  1'b1},
      {3'b000, 4'b1111, 16'h8000, 1'b0, 1'b1, 4'd15, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // raise the request line; sample the forwarded strobe
   task automatic request(input logic fs, fp, fc, input logic [3:0] hi, input logic [15:0] mask);
      @(negedge clk);
      bus_fm_sel = fs; fm_present = fp; fm_claim = fc;
      bus_hi_lines = hi; core_present = mask;
      bus_rq_cyc = 1'b1;
      @(posedge clk); #2;
   endtask

   task automatic drop_rq();
      @(negedge clk);
      bus_rq_cyc = 1'b0;
   endtask

   task automatic ack_pulse();
      @(negedge clk);
      mem_addr_ack = 1'b1;
      @(posedge clk); #2;
      chk("R7 ack pulse", proc_addr_ack, 1);
      @(negedge clk);
      mem_addr_ack = 1'b0;
      @(posedge clk); #2;
      chk("R7 ack one cycle", proc_addr_ack, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk); #2;
      // R9: outputs quiet in reset
      chk("R9 reset strobes", {fm_rq, fm_wr, proc_addr_ack, proc_rd_rs, nxm}, 0);
      chk("R9 reset core", {core_rq, core_wr}, 0);
      @(negedge clk); rst_n = 1'b1;

      // R2 R3 R4 R5 vector walk
      for (int v = 0; v < NV; v++) begin
         logic [29:0] w;
         logic [15:0] ecore;
         w = VECS[v];
         ecore = w[5] ? (16'h1 << w[4:1]) : 16'h0;
         request(w[29], w[28], w[27], w[26:23], w[22:7]);
         chk($sformatf("R2 fast strobe v%0d", v), fm_rq, w[6]);
         chk($sformatf("R4 core strobe v%0d", v), core_rq, ecore);
         chk($sformatf("R5 nxm v%0d", v), nxm, w[0]);
         drop_rq();
         ack_pulse();
      end

      // R1: held request gives one strobe only
      request(1'b0, 1'b0, 1'b0, 4'b0001, 16'hFFFF);
      chk("R1 strobe on edge", core_rq, 16'h0100);
      repeat (2) @(posedge clk); #2;
      chk("R1 no repeat while held", core_rq, 0);
      drop_rq();
      ack_pulse();

      // R6: write restart to core target, held high
      @(negedge clk); bus_wr_rs = 1'b1;
      @(posedge clk); #2;
      chk("R6 core write restart", core_wr, 16'h0100);
      chk("R6 fast write idle", fm_wr, 0);
      @(posedge clk); #2;
      chk("R6 write restart once", core_wr, 0);
      @(negedge clk); bus_wr_rs = 1'b0;

      // R6: fast target
      request(1'b1, 1'b1, 1'b1, 4'b0000, 16'hFFFF);
      drop_rq();
      ack_pulse();
      @(negedge clk); bus_wr_rs = 1'b1;
      @(posedge clk); #2;
      chk("R6 fast write restart", fm_wr, 1);
      chk("R6 core write idle", core_wr, 0);
      @(negedge clk); bus_wr_rs = 1'b0;

      // R6: after nonexistent memory a write restart does nothing
      request(1'b0, 1'b0, 1'b0, 4'b0001, 16'h0000);
      chk("R5 nxm before write", nxm, 1);
      drop_rq();
      @(negedge clk); bus_wr_rs = 1'b1;
      @(posedge clk); #2;
      chk("R6 no write after nxm", {fm_wr, core_wr}, 0);
      @(negedge clk); bus_wr_rs = 1'b0;

      // R7: read restart
      @(negedge clk); mem_rd_rs = 1'b1;
      @(posedge clk); #2;
      chk("R7 read restart pulse", proc_rd_rs, 1);
      @(posedge clk); #2;
      chk("R7 read restart one cycle", proc_rd_rs, 0);
      @(negedge clk); mem_rd_rs = 1'b0;

      // R8: timeout without acknowledge
      request(1'b0, 1'b0, 1'b0, 4'b1000, 16'hFFFF);
      chk("R8 routed strobe", core_rq, 16'h0002);
      for (int i = 1; i < TO; i++) begin
         @(posedge clk); #2;
         chk($sformatf("R8 quiet edge %0d", i), nxm, 0);
      end
      @(posedge clk); #2;
      chk("R8 timeout nxm", nxm, 1);
      @(posedge clk); #2;
      chk("R8 timeout one cycle", nxm, 0);
      drop_rq();

      // R8: acknowledge at the last edge cancels
      request(1'b0, 1'b0, 1'b0, 4'b1000, 16'hFFFF);
      for (int i = 1; i < TO - 1; i++) @(posedge clk);
      @(negedge clk); mem_addr_ack = 1'b1; bus_rq_cyc = 1'b0;
      repeat (4) begin
         @(posedge clk); #2;
         chk("R8 ack cancels timeout", nxm, 0);
      end
      @(negedge clk); mem_addr_ack = 1'b0;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule